// File: doc/BRIEF.md
# CAN Error Flag and Code Capture Unit

This block latches the error events reported by a CAN protocol engine and turns them into a single summary error interrupt. The protocol engine sends one-cycle pulses: eight event classes feed a flag register, and seven protocol error classes feed a code register. Software reaches three byte-wide registers through a simple write strobe and a combinational read port. The three registers are the event flags, a per-flag enable mask, and the error code with its mode bit.

Software clears a flag by writing a byte that holds 0 in that bit and 1 in every other bit. Bits written as 1 keep their value. This lets software acknowledge one event without a read-modify-write race. The code register has two modes. In replace mode, each new set of protocol error codes overwrites the old one. In accumulate mode, new codes are ORed into the codes already held. Error counters and the error-state logic sit outside this block. Only their threshold-crossing events arrive here as pulses.

Top module: `can_errcap`

## Requirements
- R1: After reset the flag, enable and code registers read 0x00 and `irq_o` is low.
- R2: An `evt_i` pulse sets the matching flag bit in the flag register, visible one cycle later. Bit positions, from 7 down to 0: bus lock, overload frame sent, receive overrun, bus-off recovery, bus-off entry, error passive, error warning, bus error. A flag stays set without further pulses.
- R3: A write with `wr_sel_i` = 0 clears each flag bit written as 0. Each flag bit written as 1 keeps its value, so writing 0xFF changes nothing.
- R4: If an event pulse and a clear of the same bit fall in the same cycle, the flag is set afterwards. The same holds for code bits.
- R5: A write with `wr_sel_i` = 1 loads the enable register as written. Enable bit n masks flag bit n.
- R6: `irq_o` is high exactly when at least one flag bit is set and its enable bit is also set. It stays high until every enabled flag is cleared or disabled. A set flag whose enable bit is 0 does not raise it.
- R7: In the code register (`wr_sel_i` = 2), bit 7 is the mode bit and is written directly. Bits 6:0 follow the same clear-by-zero rule as the flags. Their meaning, from bit 6 down: ACK-delimiter error, bit error while sending dominant, bit error while sending recessive, CRC error, ACK error, form error, stuff error. `code_evt_i[k]` drives code bit k.
- R8: With mode bit 7 = 1, a nonzero `code_evt_i` is ORed into code bits 6:0.
- R9: With mode bit 7 = 0, a nonzero `code_evt_i` replaces code bits 6:0 entirely. In both modes, a `code_evt_i` of zero leaves the codes untouched.
- R10: `wr_sel_i` = 3 is unused. Writes to it change no register, and reads from it return 0x00.
- R11: `rd_data_o` shows, with no clock delay, the register chosen by `rd_sel_i`: 0 selects the flags, 1 the enables, 2 the code register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| evt_i | input | 8 | One-cycle error event pulses, one per flag bit |
| code_evt_i | input | 7 | One-cycle protocol error code pulses |
| wr_en_i | input | 1 | Register write strobe |
| wr_sel_i | input | 2 | Register selected for the write |
| wr_data_i | input | 8 | Write data |
| rd_sel_i | input | 2 | Register selected for the read |
| rd_data_o | output | 8 | Read data |
| flags_o | output | 8 | Current flag register |
| enable_o | output | 8 | Current enable register |
| code_o | output | 8 | Current code register (bit 7 is the mode bit) |
| irq_o | output | 1 | Summary error interrupt |

## Verification
The bench checks clears that hit one bit while other flags are set. A design that cleared on a written 1, or cleared the whole byte, would lose the other flags. It drives an event and a clear of the same bit in the same cycle. A design that let the clear win would drop the event. It changes the code mode and feeds overlapping code sets. A wrong mode decode would OR codes that should be replaced, or the reverse. It sets a flag whose enable bit is 0, then removes the enabled flags one at a time. An interrupt that ignored the mask or dropped too early would show up here, as would a write to the unused select that corrupted a register.

// File: rtl/can_errcap_pkg.sv
package can_errcap_pkg;

    localparam int DATA_W = 8;
    localparam int SEL_W  = 2;

    typedef enum logic [SEL_W-1:0] {
        SEL_FLAGS  = 2'd0,
        SEL_ENABLE = 2'd1,
        SEL_CODE   = 2'd2,
        SEL_UNUSED = 2'd3
    } reg_sel_e;

    // flag bit positions (decoded by software)
    localparam int FLG_BUS_ERR    = 0;
    localparam int FLG_WARN       = 1;
    localparam int FLG_PASSIVE    = 2;
    localparam int FLG_BOFF_ENTRY = 3;
    localparam int FLG_BOFF_RECOV = 4;
    localparam int FLG_RX_OVERRUN = 5;
    localparam int FLG_OVERLOAD   = 6;
    localparam int FLG_BUS_LOCK   = 7;

    // code bit positions
    localparam int CODE_STUFF    = 0;
    localparam int CODE_FORM     = 1;
    localparam int CODE_ACK      = 2;
    localparam int CODE_CRC      = 3;
    localparam int CODE_BIT_REC  = 4;
    localparam int CODE_BIT_DOM  = 5;
    localparam int CODE_ACK_DELIM= 6;
    localparam int CODE_MODE     = 7;

endpackage

// File: rtl/can_errcap_flags.sv
module can_errcap_flags #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] evt_i,
    input  logic         clr_en_i,
    input  logic [W-1:0] clr_data_i,
    output logic [W-1:0] flags_o
);

    typedef struct packed {
        logic [W-1:0] flags;
    } state_t;

    state_t st_d, st_q;
    logic [W-1:0] keep_mask;

    // a 0 written to a bit clears it; a 1 leaves it alone
    assign keep_mask = clr_en_i ? clr_data_i : {W{1'b1}};

    always_comb begin
        st_d = st_q;
        for (int i = 0; i < W; i++) begin
            // event has priority over a clear in the same cycle
            st_d.flags[i] = evt_i[i] | (st_q.flags[i] & keep_mask[i]);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign flags_o = st_q.flags;

endmodule

// File: rtl/can_errcap_code.sv
module can_errcap_code #(
    parameter int W = 7
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] code_evt_i,
    input  logic         wr_en_i,
    input  logic [W:0]   wr_data_i,
    output logic [W:0]   code_o
);

    typedef struct packed {
        logic         accum;
        logic [W-1:0] codes;
    } state_t;

    state_t st_d, st_q;
    logic [W-1:0] kept;
    logic         new_err;

    assign new_err = |code_evt_i;

    always_comb begin
        kept = st_q.codes;
        if (wr_en_i) kept = st_q.codes & wr_data_i[W-1:0];
    end

    always_comb begin
        st_d = st_q;
        if (wr_en_i) st_d.accum = wr_data_i[W];
        // mode in force is the one held before this cycle
        if (st_q.accum)    st_d.codes = kept | code_evt_i;
        else if (new_err)  st_d.codes = code_evt_i;
        else               st_d.codes = kept;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign code_o = {st_q.accum, st_q.codes};

endmodule

// File: rtl/can_errcap_regif.sv
module can_errcap_regif
    import can_errcap_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en_i,
    input  logic [SEL_W-1:0] wr_sel_i,
    input  logic [DW-1:0]    wr_data_i,
    input  logic [SEL_W-1:0] rd_sel_i,
    input  logic [DW-1:0]    flags_i,
    input  logic [DW-1:0]    code_i,
    output logic             flags_wr_o,
    output logic             code_wr_o,
    output logic [DW-1:0]    enable_o,
    output logic [DW-1:0]    rd_data_o
);

    typedef struct packed {
        logic [DW-1:0] enable;
    } state_t;

    state_t st_d, st_q;

    assign flags_wr_o = wr_en_i && (reg_sel_e'(wr_sel_i) == SEL_FLAGS);
    assign code_wr_o  = wr_en_i && (reg_sel_e'(wr_sel_i) == SEL_CODE);

    always_comb begin
        st_d = st_q;
        if (wr_en_i && reg_sel_e'(wr_sel_i) == SEL_ENABLE) st_d.enable = wr_data_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign enable_o = st_q.enable;

    always_comb begin
        unique case (reg_sel_e'(rd_sel_i))
            SEL_FLAGS:  rd_data_o = flags_i;
            SEL_ENABLE: rd_data_o = st_q.enable;
            SEL_CODE:   rd_data_o = code_i;
            default:    rd_data_o = '0;
        endcase
    end

endmodule

// File: rtl/can_errcap.sv
module can_errcap
    import can_errcap_pkg::*;
#(
    parameter int FLAG_W = 8,
    parameter int CODE_W = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [FLAG_W-1:0] evt_i,
    input  logic [CODE_W-1:0] code_evt_i,
    input  logic              wr_en_i,
    input  logic [SEL_W-1:0]  wr_sel_i,
    input  logic [FLAG_W-1:0] wr_data_i,
    input  logic [SEL_W-1:0]  rd_sel_i,
    output logic [FLAG_W-1:0] rd_data_o,
    output logic [FLAG_W-1:0] flags_o,
    output logic [FLAG_W-1:0] enable_o,
    output logic [FLAG_W-1:0] code_o,
    output logic              irq_o
);

    localparam int CODE_REG_W = CODE_W + 1;

    logic flags_wr, code_wr;
    logic [CODE_REG_W-1:0] code_reg;

    can_errcap_flags #(.W(FLAG_W)) u_flags (
        .clk        (clk),
        .rst_n      (rst_n),
        .evt_i      (evt_i),
        .clr_en_i   (flags_wr),
        .clr_data_i (wr_data_i),
        .flags_o    (flags_o)
    );

    can_errcap_code #(.W(CODE_W)) u_code (
        .clk        (clk),
        .rst_n      (rst_n),
        .code_evt_i (code_evt_i),
        .wr_en_i    (code_wr),
        .wr_data_i  (wr_data_i[CODE_REG_W-1:0]),
        .code_o     (code_reg)
    );

    generate
        if (CODE_REG_W < FLAG_W) begin : g_code_pad
            assign code_o = {{(FLAG_W-CODE_REG_W){1'b0}}, code_reg};
        end else begin : g_code_fit
            assign code_o = code_reg[FLAG_W-1:0];
        end
    endgenerate

    can_errcap_regif #(.DW(FLAG_W)) u_regif (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en_i    (wr_en_i),
        .wr_sel_i   (wr_sel_i),
        .wr_data_i  (wr_data_i),
        .rd_sel_i   (rd_sel_i),
        .flags_i    (flags_o),
        .code_i     (code_o),
        .flags_wr_o (flags_wr),
        .code_wr_o  (code_wr),
        .enable_o   (enable_o),
        .rd_data_o  (rd_data_o)
    );

    assign irq_o = |(flags_o & enable_o);

endmodule

// File: rtl/can_errcap_chk.sv
module can_errcap_chk (
    input logic       clk,
    input logic       rst_n,
    input logic [7:0] evt_i,
    input logic [6:0] code_evt_i,
    input logic       wr_en_i,
    input logic [1:0] wr_sel_i,
    input logic [7:0] wr_data_i,
    input logic [7:0] flags_o,
    input logic [7:0] enable_o,
    input logic [7:0] code_o,
    input logic       irq_o
);

    // R2
    no_phantom_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_i == 8'h00) |=> ((flags_o & ~$past(flags_o)) == 8'h00));

    // R4
    event_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_i != 8'h00) |=> ((flags_o & $past(evt_i)) == $past(evt_i)));

    // R3
    ones_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && wr_sel_i == 2'd0 && wr_data_i == 8'hFF && evt_i == 8'h00)
        |=> (flags_o == $past(flags_o)));

    // R6
    irq_has_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> ((flags_o & enable_o) != 8'h00));

    // R6
    irq_raised_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((flags_o & enable_o) != 8'h00) |-> irq_o);

    // R8
    accumulate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (code_o[7] && code_evt_i != 7'h00 && !wr_en_i)
        |=> (code_o[6:0] == ($past(code_o[6:0]) | $past(code_evt_i))));

    // R9
    replace_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!code_o[7] && code_evt_i != 7'h00 && !wr_en_i)
        |=> (code_o[6:0] == $past(code_evt_i)));

    // R10
    unused_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && wr_sel_i == 2'd3 && evt_i == 8'h00 && code_evt_i == 7'h00)
        |=> ($stable(flags_o) && $stable(enable_o) && $stable(code_o)));

endmodule

bind can_errcap can_errcap_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .evt_i      (evt_i),
    .code_evt_i (code_evt_i),
    .wr_en_i    (wr_en_i),
    .wr_sel_i   (wr_sel_i),
    .wr_data_i  (wr_data_i),
    .flags_o    (flags_o),
    .enable_o   (enable_o),
    .code_o     (code_o),
    .irq_o      (irq_o)
);

// File: tb/can_errcap_tb.sv
module can_errcap_tb;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] evt_i = '0;
    logic [6:0] code_evt_i = '0;
    logic       wr_en_i = 1'b0;
    logic [1:0] wr_sel_i = '0;
    logic [7:0] wr_data_i = '0;
    logic [1:0] rd_sel_i = '0;
    logic [7:0] rd_data_o, flags_o, enable_o, code_o;
    logic       irq_o;

    always #5 clk = ~clk;

    can_errcap u_dut (
        .clk(clk), .rst_n(rst_n), .evt_i(evt_i), .code_evt_i(code_evt_i),
        .wr_en_i(wr_en_i), .wr_sel_i(wr_sel_i), .wr_data_i(wr_data_i),
        .rd_sel_i(rd_sel_i), .rd_data_o(rd_data_o), .flags_o(flags_o),
        .enable_o(enable_o), .code_o(code_o), .irq_o(irq_o)
    );

    typedef struct {
        logic [7:0] fl;
        logic [7:0] en;
        logic [7:0] cd;
        logic [7:0] rd;
        logic       irq;
        string      tag;
    } exp_t;

    exp_t sb[$];
    int   n_vec = 0;
    int   n_bad = 0;
    bit   done = 0;

    // reference state
    logic [7:0] m_fl = '0, m_en = '0, m_cd = '0;

    function automatic logic [7:0] pick(input logic [1:0] s);
        case (s)
            2'd0: return m_fl;
            2'd1: return m_en;
            2'd2: return m_cd;
            default: return 8'h00;
        endcase
    endfunction

    task automatic step(input logic [7:0] ev, input logic [6:0] cev,
                        input logic we, input logic [1:0] ws, input logic [7:0] wd,
                        input logic [1:0] rs, input string tag);
        exp_t e;
        logic [6:0] keep;
        @(negedge clk);
        evt_i = ev; code_evt_i = cev; wr_en_i = we; wr_sel_i = ws;
        wr_data_i = wd; rd_sel_i = rs;
        m_fl = (m_fl & ((we && ws == 2'd0) ? wd : 8'hFF)) | ev;
        keep = (we && ws == 2'd2) ? wd[6:0] : 7'h7F;
        if (m_cd[7])          m_cd[6:0] = (m_cd[6:0] & keep) | cev;
        else if (cev != 0)    m_cd[6:0] = cev;
        else                  m_cd[6:0] = m_cd[6:0] & keep;
        if (we && ws == 2'd2) m_cd[7] = wd[7];
        if (we && ws == 2'd1) m_en = wd;
        e.fl = m_fl; e.en = m_en; e.cd = m_cd; e.rd = pick(rs);
        e.irq = |(m_fl & m_en); e.tag = tag;
        sb.push_back(e);
    endtask

    task automatic idle(input logic [1:0] rs, input string tag);
        step(8'h00, 7'h00, 1'b0, 2'd0, 8'h00, rs, tag);
    endtask

    // monitor: compares after each rising edge, away from it
    always @(posedge clk) begin
        #2;
        if (sb.size() > 0) begin
            exp_t e;
            e = sb.pop_front();
            n_vec++;
            if (flags_o !== e.fl || enable_o !== e.en || code_o !== e.cd ||
                rd_data_o !== e.rd || irq_o !== e.irq) begin
                n_bad++;
                $display("FAIL %s: flags=%h en=%h code=%h rd=%h irq=%b exp flags=%h en=%h code=%h rd=%h irq=%b",
                         e.tag, flags_o, enable_o, code_o, rd_data_o, irq_o,
                         e.fl, e.en, e.cd, e.rd, e.irq);
            end
        end
    end

    initial begin
        #(200000 * 10);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: run hung, act=running exp=finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state, read each register
        #1;
        n_vec++;
        if (flags_o !== 0 || enable_o !== 0 || code_o !== 0 || irq_o !== 0) begin
            n_bad++;
            $display("FAIL R1: flags=%h en=%h code=%h irq=%b exp all zero",
                     flags_o, enable_o, code_o, irq_o);
        end
        rst_n = 1'b1;
        idle(2'd0, "R1_flags");
        idle(2'd1, "R1_enable");
        idle(2'd2, "R1_code");
        // R2 events set flags and hold; irq masked (enable 0) R6
        step(8'h01, 7'h00, 0, 2'd0, 8'h00, 2'd0, "R2_bus_err");
        step(8'h88, 7'h00, 0, 2'd0, 8'h00, 2'd0, "R2_lock_boff");
        idle(2'd0, "R2_hold");
        // R5 enable write, R11 reads, R6 irq
        step(8'h00, 7'h00, 1, 2'd1, 8'h08, 2'd1, "R5_enable");
        idle(2'd0, "R11_read_flags");
        // R3 clear bit 3 only
        step(8'h00, 7'h00, 1, 2'd0, 8'hF7, 2'd0, "R3_clear_one");
        step(8'h00, 7'h00, 1, 2'd0, 8'hFF, 2'd0, "R3_ones_noop");
        // R6 masked flags present, enable two, clear one by one
        step(8'h06, 7'h00, 1, 2'd1, 8'h06, 2'd1, "R6_two_enabled");
        step(8'h00, 7'h00, 1, 2'd0, 8'hFB, 2'd0, "R6_one_left");
        step(8'h00, 7'h00, 1, 2'd0, 8'hFD, 2'd0, "R6_all_cleared");
        // R4 event and clear same bit
        step(8'h20, 7'h00, 1, 2'd0, 8'hDF, 2'd0, "R4_event_wins");
        step(8'h00, 7'h00, 1, 2'd0, 8'h00, 2'd0, "R3_clear_all");
        // R9 replace mode (default)
        step(8'h00, 7'h03, 0, 2'd0, 8'h00, 2'd2, "R9_first_code");
        step(8'h00, 7'h48, 0, 2'd0, 8'h00, 2'd2, "R9_replace");
        idle(2'd2, "R9_no_code_keeps");
        // R7 clear a code bit, set mode
        step(8'h00, 7'h00, 1, 2'd2, 8'hBF, 2'd2, "R7_clear_and_mode");
        // R8 accumulate
        step(8'h00, 7'h11, 0, 2'd0, 8'h00, 2'd2, "R8_accum1");
        step(8'h00, 7'h22, 0, 2'd0, 8'h00, 2'd2, "R8_accum2");
        // R4 on code bits
        step(8'h00, 7'h01, 1, 2'd2, 8'hFE, 2'd2, "R4_code_event_wins");
        // R7 back to replace mode
        step(8'h00, 7'h00, 1, 2'd2, 8'h7F, 2'd2, "R7_mode_off");
        step(8'h00, 7'h04, 0, 2'd0, 8'h00, 2'd2, "R9_replace_after_accum");
        // R10 unused select
        step(8'h00, 7'h00, 1, 2'd3, 8'h00, 2'd3, "R10_write_ignored");
        idle(2'd1, "R10_enable_intact");
        idle(2'd3, "R10_read_zero");
        repeat (3) @(negedge clk);
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule